// File: doc/BRIEF.md
# Loopback Frame Serializer with Selectable Frame Check

This block turns one packet held in a byte buffer into a serial bit stream on a loopback path. A start pulse launches a frame. The block first sends a fixed header: an alternating training pattern and then a start-of-frame delimiter. It then pops payload bytes from the buffer and sends them bit by bit. It can close the frame with a 32-bit frame check sequence that it computes itself. A count-down register, loaded from the byte count at start, controls how many bytes it takes. The block raises a refill request whenever the buffer runs low while bytes are still owed.

With CRC inhibit set, the block computes no frame check. The buffer contents go out untouched, so software can place its own check bytes at the tail of the payload, and the frame ends on the last bit of the last buffered byte. Bits advance only on cycles where the bit-enable input is high. This lets the block run at a line rate below the clock rate. A sticky done flag marks each completed frame and stays set until it is cleared by writing a 1.

Top module: `lbk_frame_tx`

## Requirements
- R1: During and after reset the block is idle: busy, ser_strobe, ser_out, buf_rd, refill_req and done are all 0.
- R2: Each frame starts with 56 alternating bits, the first of them a 1. An 8-bit delimiter of value 0xD5 follows, sent least significant bit first (1,0,1,0,1,0,1,1).
- R3: One bit is sent for each cycle in which bit_en is high while a frame is in progress, and no bit is sent otherwise. ser_strobe marks the cycle in which ser_out carries a new bit. Payload bytes go out least significant bit first.
- R4: buf_rd pulses once per payload byte, in the cycle that byte's first bit is taken, and the number of pulses equals byte_count. A byte_count of 0 gives a frame with no payload and no buffer reads.
- R5: refill_req is high exactly when a frame is in progress, at least one payload byte is still owed, and buf_level is below refill_thresh.
- R6: With crc_inhibit at 0, the payload is followed by 32 frame-check bits. These are CRC-32 with generator 0x04C11DB7, preset to all ones, processed in bit-reflected order and complemented, and sent least significant bit first. For the ASCII payload "123456789" the appended value is 0xCBF43926.
- R7: With crc_inhibit at 1, no check bits are appended, and the frame's last bit is bit 7 of the last payload byte.
- R8: done becomes 1 on the clock edge that sends the frame's final bit. It stays set until a cycle with done_clr at 1 clears it. A frame ending in the same cycle takes priority over the clear.
- R9: A start pulse while a frame is in progress has no effect. byte_count and crc_inhibit are sampled only at an accepted start.
- R10: busy is high from the edge after an accepted start until the edge that sends the final bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Line-rate enable: one bit advances per high cycle |
| start | input | 1 | Start pulse, accepted when idle |
| byte_count | input | CNT_W | Payload length in bytes, sampled at start |
| crc_inhibit | input | 1 | 1 = no frame check generated, sampled at start |
| buf_data | input | 8 | Byte at the head of the buffer (show-ahead) |
| buf_level | input | LVL_W | Number of bytes currently in the buffer |
| refill_thresh | input | LVL_W | Level below which a refill is requested |
| done_clr | input | 1 | Write-one-to-clear for done |
| buf_rd | output | 1 | Pops the head byte of the buffer at the next edge |
| ser_out | output | 1 | Serial data |
| ser_strobe | output | 1 | ser_out carries a new bit this cycle |
| refill_req | output | 1 | Buffer should receive another burst |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky frame-complete flag |

## Verification
The assertions assume that the buffer is never empty in a cycle where the block pops it. They check that assumption on buf_rd together with buf_level. The stimulus loads at least the first payload byte into the bench buffer model before any pop can occur. It relies on the 64-bit header to give the bench time to top up the buffer. Start and done_clr are one-cycle pulses driven away from the clock edge. Byte counts stay small enough that the buffer level never exceeds its port width.

// File: rtl/lbk_tx_pkg.sv
// Shared definitions for the loopback frame serializer.
// Assumes the delimiter is always one byte wide.
package lbk_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_FCS  = 2'd3
    } tx_state_t;

    localparam logic [31:0] FCS_POLY_REFL = 32'hEDB88320;
    localparam logic [7:0]  DELIM_PATTERN = 8'hD5;
    localparam int          FCS_BITS      = 32;
endpackage

// File: rtl/lbk_hdr_bits.sv
// Header bit generator: returns the header bit at position idx.
// The positions below PRE_BITS alternate and start with 1. The last
// eight positions give the delimiter, least significant bit first.
// Assumes idx < PRE_BITS + 8.
module lbk_hdr_bits #(
    parameter int PRE_BITS = 56,
    parameter int IDX_W    = 6
) (
    input  logic [IDX_W-1:0] idx,
    output logic             hdr_bit
);
    import lbk_tx_pkg::*;

    logic [IDX_W-1:0] delim_pos;

    // Choose the training bit or the delimiter bit for this position.
    always_comb begin
        delim_pos = idx - IDX_W'(PRE_BITS);
        if (int'(idx) < PRE_BITS) hdr_bit = ~idx[0];
        else                      hdr_bit = DELIM_PATTERN[delim_pos[2:0]];
    end
endmodule

// File: rtl/lbk_crc32.sv
// Bit-serial frame check register in reflected form.
// clear presets it to all ones, update folds in one data bit, and drain
// shifts the register out so that fcs_bit walks through the complemented
// result, least significant bit first. At most one control is high per cycle.
module lbk_crc32 (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic update,
    input  logic din,
    input  logic drain,
    output logic fcs_bit
);
    import lbk_tx_pkg::*;

    logic [31:0] crc_q;

    // Preset, accumulate or shift out the check register.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= '1;
        else if (clear)  crc_q <= '1;
        else if (update) crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ din) ? FCS_POLY_REFL : 32'h0);
        else if (drain)  crc_q <= {1'b1, crc_q[31:1]};
    end

    assign fcs_bit = ~crc_q[0];
endmodule

// File: rtl/lbk_fetch_ctrl.sv
// Payload fetch bookkeeping: a count-down of bytes still owed, loaded at
// start and decremented on each pop. It raises a refill request while
// bytes are owed and the buffer is below its threshold.
// Assumes take is never high while the count is already zero.
module lbk_fetch_ctrl #(
    parameter int CNT_W = 16,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             take,
    input  logic             active,
    input  logic [LVL_W-1:0] buf_level,
    input  logic [LVL_W-1:0] refill_thresh,
    output logic             owed_zero,
    output logic             refill_req
);
    logic [CNT_W-1:0] owed_q;

    // Load the byte count at start, count it down per popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    owed_q <= '0;
        else if (load) owed_q <= load_val;
        else if (take) owed_q <= owed_q - 1'b1;
    end

    assign owed_zero  = (owed_q == '0);
    assign refill_req = active && !owed_zero && (buf_level < refill_thresh);
endmodule

// File: rtl/lbk_frame_tx.sv
// Loopback frame serializer. On an idle start it sends the header, then
// byte_count payload bytes popped from a show-ahead buffer, least
// significant bit first, and then, unless inhibited, the 32-bit check.
// It assumes the buffer holds a byte whenever buf_rd is asserted, and
// that start and done_clr are single-cycle pulses.
module lbk_frame_tx #(
    parameter int CNT_W    = 16,
    parameter int LVL_W    = 5,
    parameter int PRE_BITS = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             crc_inhibit,
    input  logic [7:0]       buf_data,
    input  logic [LVL_W-1:0] buf_level,
    input  logic [LVL_W-1:0] refill_thresh,
    input  logic             done_clr,
    output logic             buf_rd,
    output logic             ser_out,
    output logic             ser_strobe,
    output logic             refill_req,
    output logic             busy,
    output logic             done
);
    import lbk_tx_pkg::*;

    localparam int HDR_BITS = PRE_BITS + 8;
    localparam int HCNT_W   = $clog2(HDR_BITS);
    localparam int FCNT_W   = $clog2(FCS_BITS);

    tx_state_t         state_q;
    logic [HCNT_W-1:0] hcnt_q;
    logic [2:0]        bidx_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic [7:0]        shreg_q;
    logic              inh_q;

    logic accept, load_byte, data_bit, hdr_bit, fcs_bit, owed_zero;
    logic hdr_last, byte_last, fcs_last, frame_end;

    // Decode the per-cycle events that steer the datapath.
    always_comb begin
        accept    = (state_q == ST_IDLE) && start;
        load_byte = (state_q == ST_DATA) && bit_en && (bidx_q == 3'd0);
        data_bit  = load_byte ? buf_data[0] : shreg_q[bidx_q];
        hdr_last  = (state_q == ST_HDR) && bit_en && (hcnt_q == HCNT_W'(HDR_BITS - 1));
        byte_last = (state_q == ST_DATA) && bit_en && (bidx_q == 3'd7);
        fcs_last  = (state_q == ST_FCS) && bit_en && (fcnt_q == FCNT_W'(FCS_BITS - 1));
        frame_end = fcs_last || (inh_q && owed_zero && (hdr_last || byte_last));
    end

    assign buf_rd = load_byte;
    assign busy   = (state_q != ST_IDLE);

    lbk_hdr_bits #(
        .PRE_BITS (PRE_BITS),
        .IDX_W    (HCNT_W)
    ) u_hdr (
        .idx     (hcnt_q),
        .hdr_bit (hdr_bit)
    );

    lbk_crc32 u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .update  ((state_q == ST_DATA) && bit_en),
        .din     (data_bit),
        .drain   ((state_q == ST_FCS) && bit_en),
        .fcs_bit (fcs_bit)
    );

    lbk_fetch_ctrl #(
        .CNT_W (CNT_W),
        .LVL_W (LVL_W)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (accept),
        .load_val      (byte_count),
        .take          (load_byte),
        .active        (busy),
        .buf_level     (buf_level),
        .refill_thresh (refill_thresh),
        .owed_zero     (owed_zero),
        .refill_req    (refill_req)
    );

    // Sequence header, payload and check phases and drive the serial line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hcnt_q     <= '0;
            bidx_q     <= '0;
            fcnt_q     <= '0;
            shreg_q    <= '0;
            inh_q      <= 1'b0;
            ser_out    <= 1'b0;
            ser_strobe <= 1'b0;
        end else begin
            ser_strobe <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    ser_out <= 1'b0;
                    if (start) begin
                        state_q <= ST_HDR;
                        hcnt_q  <= '0;
                        inh_q   <= crc_inhibit;
                    end
                end
                ST_HDR: if (bit_en) begin
                    ser_out    <= hdr_bit;
                    ser_strobe <= 1'b1;
                    hcnt_q     <= hcnt_q + 1'b1;
                    if (hdr_last) begin
                        fcnt_q <= '0;
                        bidx_q <= '0;
                        if (!owed_zero)  state_q <= ST_DATA;
                        else if (inh_q)  state_q <= ST_IDLE;
                        else             state_q <= ST_FCS;
                    end
                end
                ST_DATA: if (bit_en) begin
                    ser_out    <= data_bit;
                    ser_strobe <= 1'b1;
                    bidx_q     <= bidx_q + 1'b1;
                    if (load_byte) shreg_q <= buf_data;
                    if (byte_last && owed_zero) begin
                        fcnt_q  <= '0;
                        state_q <= inh_q ? ST_IDLE : ST_FCS;
                    end
                end
                ST_FCS: if (bit_en) begin
                    ser_out    <= fcs_bit;
                    ser_strobe <= 1'b1;
                    fcnt_q     <= fcnt_q + 1'b1;
                    if (fcs_last) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky completion flag, write-one-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         done <= 1'b0;
        else if (frame_end) done <= 1'b1;
        else if (done_clr)  done <= 1'b0;
    end
endmodule

// File: rtl/lbk_frame_tx_chk.sv
// Property checker for the loopback frame serializer, bound to every
// instance of the top module. Observes ports only.
module lbk_frame_tx_chk #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             start,
    input logic [LVL_W-1:0] buf_level,
    input logic             done_clr,
    input logic             buf_rd,
    input logic             ser_strobe,
    input logic             refill_req,
    input logic             busy,
    input logic             done
);
    // R3
    strobe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_strobe |-> $past(bit_en));
    // R3
    idle_sends_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !ser_strobe);
    // R4
    pop_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> busy);
    // R4
    pop_never_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> (buf_level != '0));
    // R5
    refill_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> busy);
    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);
    // R8
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !busy) |=> !done);
    // R10
    start_launches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R8
    done_rises_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($fell(busy) && ser_strobe));
endmodule

bind lbk_frame_tx lbk_frame_tx_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .start      (start),
    .buf_level  (buf_level),
    .done_clr   (done_clr),
    .buf_rd     (buf_rd),
    .ser_strobe (ser_strobe),
    .refill_req (refill_req),
    .busy       (busy),
    .done       (done)
);

// File: tb/lbk_frame_tx_test.sv
`timescale 1ns/1ps
module lbk_frame_tx_test;
    localparam int CNT_W = 16;
    localparam int LVL_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic crc_inhibit = 1'b0;
    logic [7:0] buf_data;
    logic [LVL_W-1:0] buf_level;
    logic [LVL_W-1:0] refill_thresh = 5'd4;
    logic done_clr = 1'b0;
    logic buf_rd, ser_out, ser_strobe, refill_req, busy, done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // buffer model: show-ahead queue, popped on buf_rd
    logic [7:0] qmem [0:255];
    logic [7:0] wp = 8'd0;
    logic [7:0] rp = 8'd0;
    assign buf_data  = qmem[rp];
    assign buf_level = LVL_W'(wp - rp);
    always @(posedge clk) if (buf_rd) rp <= rp + 8'd1;

    // collected line bits
    logic bits [0:1023];
    int nb = 0;
    int nrd = 0;
    int back_to_back = 0;
    logic prev_strobe = 1'b0;
    int en_div = 1;
    logic [7:0] pay [0:31];

    lbk_frame_tx #(.CNT_W(CNT_W), .LVL_W(LVL_W)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
        .byte_count(byte_count), .crc_inhibit(crc_inhibit),
        .buf_data(buf_data), .buf_level(buf_level),
        .refill_thresh(refill_thresh), .done_clr(done_clr),
        .buf_rd(buf_rd), .ser_out(ser_out), .ser_strobe(ser_strobe),
        .refill_req(refill_req), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    // line-rate enable pattern
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk);
            #1;
            bit_en = (ph == 0);
            ph = (ph + 1) % en_div;
        end
    end

    always @(negedge clk) begin
        if (ser_strobe) begin
            bits[nb] = ser_out;
            nb++;
        end
        if (ser_strobe && prev_strobe) back_to_back++;
        prev_strobe = ser_strobe;
        if (buf_rd) nrd++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_fcs(input int n);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++)
                c = (c >> 1) ^ ((c[0] ^ pay[i][b]) ? 32'hEDB88320 : 32'h0);
        return ~c;
    endfunction

    function automatic logic hdr_exp(input int i);
        logic [7:0] d;
        d = 8'hD5;
        if (i < 56) return (i % 2 == 0);
        return d[i-56];
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); #1; t++; end
        @(negedge clk); #1;
    endtask

    task automatic push(input logic [7:0] b);
        qmem[wp] = b;
        wp = wp + 8'd1;
    endtask

    // compare the collected frame against the expected header/payload/check
    task automatic check_frame(input int n, input bit inh, input string tag);
        int exp_len, bad;
        logic [31:0] f;
        exp_len = 64 + 8*n + (inh ? 0 : 32);
        chk(nb == exp_len, {tag, " frame length"}, nb, exp_len);
        bad = -1;
        for (int i = 0; i < 64 && bad < 0; i++) if (bits[i] !== hdr_exp(i)) bad = i;
        chk(bad < 0, "R2 header bits", bad, -1);
        bad = -1;
        for (int i = 0; i < 8*n && bad < 0; i++) if (bits[64+i] !== pay[i/8][i%8]) bad = i;
        chk(bad < 0, "R3 payload bits lsb first", bad, -1);
        chk(nrd == n, "R4 pop count", nrd, n);
        if (!inh) begin
            f = '0;
            for (int i = 0; i < 32; i++) f[i] = bits[64+8*n+i];
            chk(f == ref_fcs(n), "R6 appended check", f, ref_fcs(n));
        end
    endtask

    task automatic run_frame(input int n, input bit inh);
        nb = 0; nrd = 0;
        for (int i = 0; i < n; i++) push(pay[i]);
        byte_count = CNT_W'(n);
        crc_inhibit = inh;
        pulse_start();
        wait_done();
    endtask

    task automatic t_reset();
        #1;
        chk(!busy && !ser_strobe && !ser_out && !buf_rd, "R1 idle outputs",
            {busy, ser_strobe, ser_out, buf_rd}, 0);
        chk(!refill_req && !done, "R1 flags clear", {refill_req, done}, 0);
    endtask

    task automatic t_check_value();
        logic [31:0] f;
        string s;
        s = "123456789";
        for (int i = 0; i < 9; i++) pay[i] = s[i];
        run_frame(9, 1'b0);
        check_frame(9, 1'b0, "R6");
        f = '0;
        for (int i = 0; i < 32; i++) f[i] = bits[64+72+i];
        chk(f == 32'hCBF43926, "R6 known check value", f, 32'hCBF43926);
        chk(done && !busy, "R8 done after frame", {done, busy}, 2'b10);
        repeat (3) @(negedge clk);
        chk(done, "R8 done sticky", done, 1);
        clear_done(); #1;
        chk(!done, "R8 done cleared", done, 0);
    endtask

    task automatic t_inhibit();
        for (int i = 0; i < 6; i++) pay[i] = 8'h3C ^ 8'(i * 37);
        pay[5] = 8'h80;
        run_frame(6, 1'b1);
        check_frame(6, 1'b1, "R7");
        chk(bits[nb-1] == 1'b1, "R7 last bit from last byte", bits[nb-1], 1);
        clear_done();
    endtask

    task automatic t_zero();
        run_frame(0, 1'b1);
        check_frame(0, 1'b1, "R4 zero count inhibit");
        clear_done();
        run_frame(0, 1'b0);
        check_frame(0, 1'b0, "R4 zero count");
        clear_done();
    endtask

    task automatic t_slow_enable();
        int t0;
        en_div = 3;
        back_to_back = 0;
        for (int i = 0; i < 3; i++) pay[i] = 8'hA0 + 8'(i);
        t0 = $time;
        run_frame(3, 1'b0);
        check_frame(3, 1'b0, "R3 slow enable");
        chk(back_to_back == 0, "R3 one bit per enable", back_to_back, 0);
        chk(($time - t0) / 10 >= 3 * 120, "R3 frame stretched", ($time - t0) / 10, 360);
        en_div = 1;
        clear_done();
    endtask

    task automatic t_refill();
        int t;
        nb = 0; nrd = 0;
        for (int i = 0; i < 6; i++) pay[i] = 8'h11 * 8'(i + 1);
        byte_count = 16'd6; crc_inhibit = 1'b1; refill_thresh = 5'd4;
        pulse_start();
        repeat (2) @(negedge clk); #1;
        chk(refill_req, "R5 empty buffer requests", refill_req, 1);
        for (int i = 0; i < 6; i++) push(pay[i]);
        #1;
        chk(!refill_req, "R5 level above threshold", refill_req, 0);
        t = 0;
        while (nrd < 3 && t < 2000) begin @(negedge clk); #1; t++; end
        @(negedge clk); #1;
        chk(refill_req, "R5 drained below threshold", refill_req, 1);
        while (nrd < 6 && t < 4000) begin @(negedge clk); #1; t++; end
        @(negedge clk); #1;
        chk(!refill_req && busy, "R5 nothing owed", {refill_req, busy}, 2'b01);
        wait_done();
        check_frame(6, 1'b1, "R5 frame");
        clear_done();
    endtask

    task automatic t_start_ignored();
        nb = 0; nrd = 0;
        for (int i = 0; i < 4; i++) begin pay[i] = 8'hC3 - 8'(i); push(pay[i]); end
        byte_count = 16'd4; crc_inhibit = 1'b0;
        pulse_start();
        #1;
        chk(busy, "R10 busy after start", busy, 1);
        byte_count = 16'd9; crc_inhibit = 1'b1;
        repeat (20) @(negedge clk);
        pulse_start();
        wait_done();
        check_frame(4, 1'b0, "R9 restart ignored");
        chk(!busy, "R10 idle after frame", busy, 0);
        clear_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_check_value();
        t_inhibit();
        t_zero();
        t_slow_enable();
        t_refill();
        t_start_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule